// File: doc/BRIEF.md
# Unified Multi-Geometry CORDIC Pipeline

This block is a fully unrolled, pipelined CORDIC datapath. It runs shift-and-add pseudorotations on a vector (x, y) and an angle accumulator z. A single instance covers three geometries: circular, linear and hyperbolic. Each geometry works in either of two steering modes. In rotation mode the accumulator is driven toward zero. In vectoring mode the y coordinate is driven toward zero.

The geometry select and the mode select travel down the pipeline together with the operands. Each operation therefore carries its own setting, and a new operation can enter on every clock. Each stage holds fixed shifters and a fixed elementary-angle constant for every geometry, and a register follows each stage.

Outputs carry the geometry gain: about 1.6468 for circular, exactly 1 for linear and about 0.8282 for hyperbolic. Gain correction and quadrant extension are left to the logic around the block. Words are 18-bit two's complement with 16 fraction bits, so the range is [-2, 2). The accumulator uses the same format, in radians for the circular geometry.

Top module: `cordic_pipe`

## Requirements
- R1: While `rst_n` is low at a rising edge, every stage register clears, so `out_valid` and `out_x`/`out_y`/`out_z` read 0 after that edge.
- R2: `out_valid` reproduces `in_valid` exactly 18 clocks later, one operation can enter on every clock, and each operation keeps the geometry and mode it entered with.
- R3: An active stage with shift S and direction c (±1) computes x' = x − m·c·(y>>>S), y' = y + c·(x>>>S), z' = z − c·a. Shifts are arithmetic. Each result is truncated to 18 bits. The constant a is round(f(2^−S)·2^16).
- R4: `in_sys` selects the geometry. 2'b00 is circular (m=+1, f=atan, shift = stage index). 2'b01 is linear (m=0, f=identity, shift = stage index + 1, and x never changes). 2'b10 is hyperbolic (m=−1, f=atanh, shifts 1,2,3,4,4,5,…,13,13,14,15,16 over all 18 stages).
- R5: Circular and linear operations use stages 0 to 15 only, and stages 16 and 17 pass them through unchanged.
- R6: With `in_mode`=0 (rotation), c=+1 exactly when the z sign bit is 0. With `in_mode`=1 (vectoring), c=+1 exactly when the x and y sign bits differ.
- R7: `in_sys`=2'b11 is a bypass: x, y and z leave after 18 clocks unchanged.
- R8: Circular rotation of (x, y) by z gives x≈1.6468(x·cos z − y·sin z), y≈1.6468(y·cos z + x·sin z) and z≈0 for |z| up to about 1.74.
- R9: Circular vectoring with z=0 and x>0 gives x≈1.6468·√(x²+y²), y≈0 and z≈atan(y/x).
- R10: Linear rotation gives y≈y+x·z. Linear vectoring with z=0 gives z≈y/x for |y/x| below 1.
- R11: Hyperbolic rotation gives x≈0.8282(x·cosh z + y·sinh z) and y≈0.8282(y·cosh z + x·sinh z). Hyperbolic vectoring with z=0 gives z≈atanh(y/x) and y≈0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_sys | input | 2 | Geometry: 00 circular, 01 linear, 10 hyperbolic, 11 bypass |
| in_mode | input | 1 | 0 rotation, 1 vectoring |
| in_x | input | 18 | x operand, Q2.16 |
| in_y | input | 18 | y operand, Q2.16 |
| in_z | input | 18 | Angle operand, Q2.16 |
| out_valid | output | 1 | Result strobe |
| out_x | output | 18 | x result |
| out_y | output | 18 | y result |
| out_z | output | 18 | Angle result |

## Verification
Assertions inside each stage check the following on every clock. The strobe and the geometry and mode tags advance by exactly one register per stage. Idle stages, and the bypass code, leave all three words untouched. Linear stages never alter x. In rotation mode, an active stage moves z toward zero according to its incoming sign. Bit-exact arithmetic, including the hyperbolic repeat schedule, the hardwired constants and the truncation on overflow, can only be shown by the bench. Its cycle model is compared on every clock over mixed back-to-back traffic. The same applies to the numerical convergence of each geometry and mode toward its closed form.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic [1:0] {
        SYS_CIRC = 2'b00,
        SYS_LIN  = 2'b01,
        SYS_HYP  = 2'b10,
        SYS_BYP  = 2'b11
    } sys_e;

    // Shift amount of hyperbolic stage k: shifts 4, 13, 40, ... are issued twice.
    function automatic int hyp_shift(input int k);
        int s;
        int r;
        bit dup;
        s   = 1;
        r   = 4;
        dup = 1'b0;
        for (int j = 0; j < k; j++) begin
            if (s == r && !dup) begin
                dup = 1'b1;
            end else begin
                if (s == r) r = 3 * r + 1;
                dup = 1'b0;
                s   = s + 1;
            end
        end
        return s;
    endfunction

    // Number of repeated hyperbolic stages needed for a given iteration count.
    function automatic int hyp_repeats(input int iter);
        int r;
        int n;
        r = 4;
        n = 0;
        while (r <= iter) begin
            n = n + 1;
            r = 3 * r + 1;
        end
        return n;
    endfunction

    // Elementary constant for one stage, scaled to LSBs and rounded.
    function automatic longint angle_lsb(input sys_e sys, input int s, input int frac);
        real t;
        real a;
        t = 2.0 ** (-s);
        case (sys)
            SYS_CIRC: a = $atan(t);
            SYS_HYP:  a = (s > 0) ? $atanh(t) : 0.0;
            default:  a = t;
        endcase
        return $rtoi(a * (2.0 ** frac) + 0.5);
    endfunction

endpackage

// File: rtl/cordic_dir.sv
module cordic_dir (
    input  logic mode_i,
    input  logic x_sign_i,
    input  logic y_sign_i,
    input  logic z_sign_i,
    output logic dir_pos_o
);

    // Rotation steers on the accumulator sign, vectoring on the x/y sign disagreement.
    always_comb begin
        if (mode_i) dir_pos_o = x_sign_i ^ y_sign_i;
        else        dir_pos_o = ~z_sign_i;
    end

endmodule

// File: rtl/cordic_xadd.sv
module cordic_xadd #(
    parameter int WIDTH = 18,
    parameter int FRAC  = 16,
    parameter int ITER  = 16,
    parameter int K     = 0
) (
    input  logic [1:0]              sys_i,
    input  logic                    dir_pos_i,
    input  logic signed [WIDTH-1:0] x_i,
    input  logic signed [WIDTH-1:0] y_i,
    input  logic signed [WIDTH-1:0] z_i,
    output logic signed [WIDTH-1:0] x_o,
    output logic signed [WIDTH-1:0] y_o,
    output logic signed [WIDTH-1:0] z_o,
    output logic                    act_o
);
    import cordic_pkg::*;

    localparam int  SH_C   = K;
    localparam int  SH_L   = K + 1;
    localparam int  SH_H   = hyp_shift(K);
    localparam int  NSTAGE = ITER + hyp_repeats(ITER);
    localparam bit  ON_CL  = (K < ITER);
    localparam bit  ON_H   = (K < NSTAGE);

    localparam longint AC_L = angle_lsb(SYS_CIRC, SH_C, FRAC);
    localparam longint AL_L = angle_lsb(SYS_LIN,  SH_L, FRAC);
    localparam longint AH_L = angle_lsb(SYS_HYP,  SH_H, FRAC);
    localparam logic signed [WIDTH-1:0] A_C = AC_L[WIDTH-1:0];
    localparam logic signed [WIDTH-1:0] A_L = AL_L[WIDTH-1:0];
    localparam logic signed [WIDTH-1:0] A_H = AH_L[WIDTH-1:0];

    logic signed [WIDTH-1:0] sxc, syc, sxl, sxh, syh;

    always_comb begin
        sxc = x_i >>> SH_C;
        syc = y_i >>> SH_C;
        sxl = x_i >>> SH_L;
        sxh = x_i >>> SH_H;
        syh = y_i >>> SH_H;

        x_o   = x_i;
        y_o   = y_i;
        z_o   = z_i;
        act_o = 1'b0;

        case (sys_e'(sys_i))
            SYS_CIRC: if (ON_CL) begin
                act_o = 1'b1;
                x_o   = dir_pos_i ? (x_i - syc) : (x_i + syc);
                y_o   = dir_pos_i ? (y_i + sxc) : (y_i - sxc);
                z_o   = dir_pos_i ? (z_i - A_C) : (z_i + A_C);
            end
            SYS_LIN: if (ON_CL) begin
                act_o = 1'b1;
                y_o   = dir_pos_i ? (y_i + sxl) : (y_i - sxl);
                z_o   = dir_pos_i ? (z_i - A_L) : (z_i + A_L);
            end
            SYS_HYP: if (ON_H) begin
                act_o = 1'b1;
                x_o   = dir_pos_i ? (x_i + syh) : (x_i - syh);
                y_o   = dir_pos_i ? (y_i + sxh) : (y_i - sxh);
                z_o   = dir_pos_i ? (z_i - A_H) : (z_i + A_H);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
    parameter int WIDTH = 18,
    parameter int FRAC  = 16,
    parameter int ITER  = 16,
    parameter int K     = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_i,
    input  logic [1:0]              sys_i,
    input  logic                    mode_i,
    input  logic signed [WIDTH-1:0] x_i,
    input  logic signed [WIDTH-1:0] y_i,
    input  logic signed [WIDTH-1:0] z_i,
    output logic                    v_o,
    output logic [1:0]              sys_o,
    output logic                    mode_o,
    output logic signed [WIDTH-1:0] x_o,
    output logic signed [WIDTH-1:0] y_o,
    output logic signed [WIDTH-1:0] z_o
);

    typedef struct packed {
        logic                    v;
        logic [1:0]              sys;
        logic                    mode;
        logic signed [WIDTH-1:0] x;
        logic signed [WIDTH-1:0] y;
        logic signed [WIDTH-1:0] z;
    } slot_t;

    slot_t slot_d, slot_q;

    logic                    dir_pos;
    logic                    act;
    logic signed [WIDTH-1:0] nx, ny, nz;

    cordic_dir u_dir (
        .mode_i    (mode_i),
        .x_sign_i  (x_i[WIDTH-1]),
        .y_sign_i  (y_i[WIDTH-1]),
        .z_sign_i  (z_i[WIDTH-1]),
        .dir_pos_o (dir_pos)
    );

    cordic_xadd #(
        .WIDTH (WIDTH),
        .FRAC  (FRAC),
        .ITER  (ITER),
        .K     (K)
    ) u_xadd (
        .sys_i     (sys_i),
        .dir_pos_i (dir_pos),
        .x_i       (x_i),
        .y_i       (y_i),
        .z_i       (z_i),
        .x_o       (nx),
        .y_o       (ny),
        .z_o       (nz),
        .act_o     (act)
    );

    always_comb begin
        slot_d.v    = v_i;
        slot_d.sys  = sys_i;
        slot_d.mode = mode_i;
        slot_d.x    = nx;
        slot_d.y    = ny;
        slot_d.z    = nz;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign v_o    = slot_q.v;
    assign sys_o  = slot_q.sys;
    assign mode_o = slot_q.mode;
    assign x_o    = slot_q.x;
    assign y_o    = slot_q.y;
    assign z_o    = slot_q.z;

    AST_VALID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v_o == $past(v_i))); // R2

    AST_TAG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sys_o == $past(sys_i) && mode_o == $past(mode_i))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(act)) |->
        (x_o == $past(x_i) && y_o == $past(y_i) && z_o == $past(z_i))); // R5, R7

    AST_LIN_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sys_i) == 2'b01) |-> (x_o == $past(x_i))); // R4

    AST_ROT_Z_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(act) && !$past(mode_i) && !$past(z_i[WIDTH-1]))
        |-> ($signed(z_o) < $signed($past(z_i)))); // R6

    AST_ROT_Z_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(act) && !$past(mode_i) && $past(z_i[WIDTH-1]))
        |-> ($signed(z_o) > $signed($past(z_i)))); // R6

endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe #(
    parameter int WIDTH = 18,
    parameter int FRAC  = 16,
    parameter int ITER  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_sys,
    input  logic                    in_mode,
    input  logic signed [WIDTH-1:0] in_x,
    input  logic signed [WIDTH-1:0] in_y,
    input  logic signed [WIDTH-1:0] in_z,
    output logic                    out_valid,
    output logic signed [WIDTH-1:0] out_x,
    output logic signed [WIDTH-1:0] out_y,
    output logic signed [WIDTH-1:0] out_z
);
    import cordic_pkg::*;

    localparam int NSTAGE = ITER + hyp_repeats(ITER);

    logic                    v_w    [NSTAGE+1];
    logic [1:0]              sys_w  [NSTAGE+1];
    logic                    mode_w [NSTAGE+1];
    logic signed [WIDTH-1:0] x_w    [NSTAGE+1];
    logic signed [WIDTH-1:0] y_w    [NSTAGE+1];
    logic signed [WIDTH-1:0] z_w    [NSTAGE+1];

    assign v_w[0]    = in_valid;
    assign sys_w[0]  = in_sys;
    assign mode_w[0] = in_mode;
    assign x_w[0]    = in_x;
    assign y_w[0]    = in_y;
    assign z_w[0]    = in_z;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        cordic_stage #(
            .WIDTH (WIDTH),
            .FRAC  (FRAC),
            .ITER  (ITER),
            .K     (g)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .v_i    (v_w[g]),
            .sys_i  (sys_w[g]),
            .mode_i (mode_w[g]),
            .x_i    (x_w[g]),
            .y_i    (y_w[g]),
            .z_i    (z_w[g]),
            .v_o    (v_w[g+1]),
            .sys_o  (sys_w[g+1]),
            .mode_o (mode_w[g+1]),
            .x_o    (x_w[g+1]),
            .y_o    (y_w[g+1]),
            .z_o    (z_w[g+1])
        );
    end

    assign out_valid = v_w[NSTAGE];
    assign out_x     = x_w[NSTAGE];
    assign out_y     = y_w[NSTAGE];
    assign out_z     = z_w[NSTAGE];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_x == '0 && out_y == '0 && out_z == '0)); // R1

endmodule

// File: tb/cordic_pipe_tb.sv
module cordic_pipe_tb;

    localparam int  CLK_PERIOD = 10;
    localparam int  W   = 18;
    localparam int  NST = 18;
    localparam real SC  = 65536.0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_sys = 2'b00;
    logic          in_mode = 1'b0;
    logic [W-1:0]  in_x = '0, in_y = '0, in_z = '0;
    logic          out_valid;
    logic [W-1:0]  out_x, out_y, out_z;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;

    typedef struct {
        int due;
        int sys;
        int x;
        int y;
        int z;
    } exp_t;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cordic_pipe u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sys    (in_sys),
        .in_mode   (in_mode),
        .in_x      (in_x),
        .in_y      (in_y),
        .in_z      (in_z),
        .out_valid (out_valid),
        .out_x     (out_x),
        .out_y     (out_y),
        .out_z     (out_z)
    );

    function automatic int wrap(input int v);
        return ((v & 32'h3FFFF) ^ 32'h20000) - 32'h20000;
    endfunction

    // Behavioural reference: the recurrence of R3 over the schedules of R4/R5.
    function automatic void model(input int sys, input int mode, input int xi,
                                  input int yi, input int zi,
                                  output int xo, output int yo, output int zo);
        int  sh[$];
        int  x, y, z, tx, ty, a, c;
        real f;
        x = wrap(xi); y = wrap(yi); z = wrap(zi);
        if (sys == 0) for (int k = 0; k < 16; k++) sh.push_back(k);
        if (sys == 1) for (int k = 0; k < 16; k++) sh.push_back(k + 1);
        if (sys == 2) for (int l = 1; l <= 16; l++) begin
            sh.push_back(l);
            if (l == 4 || l == 13) sh.push_back(l);
        end
        foreach (sh[i]) begin
            f = 2.0 ** (-sh[i]);
            if (sys == 0)      f = $atan(f);
            else if (sys == 2) f = $atanh(f);
            a = $rtoi(f * SC + 0.5);
            if (mode != 0) c = ((x < 0) != (y < 0)) ? 1 : -1;
            else           c = (z >= 0) ? 1 : -1;
            tx = x >>> sh[i];
            ty = y >>> sh[i];
            if (sys == 0)      x = wrap(x - c * ty);
            else if (sys == 2) x = wrap(x + c * ty);
            y = wrap(y + c * tx);
            z = wrap(z - c * a);
        end
        xo = x; yo = y; zo = z;
    endfunction

    task automatic send(input int sys, input int mode, input int x, input int y, input int z);
        exp_t e;
        in_valid = 1'b1;
        in_sys   = sys[1:0];
        in_mode  = mode[0];
        in_x     = x[W-1:0];
        in_y     = y[W-1:0];
        in_z     = z[W-1:0];
        e.due = cyc + NST;
        e.sys = sys;
        model(sys, mode, x, y, z, e.x, e.y, e.z);
        expq.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Per-clock comparison against the reference queue.
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (expq.size() != 0 && expq[0].due == cyc) begin
                exp_t e;
                string tag;
                e = expq.pop_front();
                tag = (e.sys == 3) ? "R7" : (e.sys == 2) ? "R3 R4 R6" : "R3 R4 R5 R6";
                if (!out_valid) begin
                    fails++;
                    $display("FAIL R2 out_valid actual=0 expected=1 at cycle %0d", cyc);
                end else if (int'($signed(out_x)) != e.x || int'($signed(out_y)) != e.y ||
                             int'($signed(out_z)) != e.z) begin
                    fails++;
                    $display("FAIL %s sys=%0d actual=(%0d,%0d,%0d) expected=(%0d,%0d,%0d)",
                             tag, e.sys, $signed(out_x), $signed(out_y), $signed(out_z),
                             e.x, e.y, e.z);
                end
            end else if (out_valid) begin
                fails++;
                $display("FAIL R2 out_valid actual=1 expected=0 at cycle %0d", cyc);
            end
        end
    end

    real kc, kh;

    task automatic acc(input int sys, input int mode, input real xr, input real yr,
                       input real zr, input real ex, input real ey, input real ez,
                       input string tag);
        real ax, ay, az, tol;
        tol = 0.004;
        idle(NST + 2);
        send(sys, mode, $rtoi(xr * SC), $rtoi(yr * SC), $rtoi(zr * SC));
        in_valid = 1'b0;
        repeat (NST - 1) @(negedge clk);
        ax = $itor($signed(out_x)) / SC;
        ay = $itor($signed(out_y)) / SC;
        az = $itor($signed(out_z)) / SC;
        checks++;
        if (!out_valid || (ax - ex) > tol || (ex - ax) > tol || (ay - ey) > tol ||
            (ey - ay) > tol || (az - ez) > tol || (ez - az) > tol) begin
            fails++;
            $display("FAIL %s actual=(%f,%f,%f) v=%0d expected=(%f,%f,%f)",
                     tag, ax, ay, az, out_valid, ex, ey, ez);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin : main
        kc = 1.0;
        for (int i = 0; i < 16; i++) kc = kc * $sqrt(1.0 + 2.0 ** (-2 * i));
        kh = 1.0;
        for (int l = 1; l <= 16; l++) begin
            kh = kh * $sqrt(1.0 - 2.0 ** (-2 * l));
            if (l == 4 || l == 13) kh = kh * $sqrt(1.0 - 2.0 ** (-2 * l));
        end

        // R1: registers cleared while reset is held, even with a strobe applied
        in_valid = 1'b1; in_x = 18'h12345; in_y = 18'h0F0F0; in_z = 18'h01234;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            checks++;
            if (out_valid || out_x != '0 || out_y != '0 || out_z != '0) begin
                fails++;
                $display("FAIL R1 actual=(%0d,%h,%h,%h) expected=(0,0,0,0)",
                         out_valid, out_x, out_y, out_z);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n    = 1'b1;
        mon_on   = 1'b1;
        idle(3);

        // R8..R11: convergence toward closed forms
        acc(0, 0, 0.5, 0.25, 0.9,
            kc * (0.5 * $cos(0.9) - 0.25 * $sin(0.9)),
            kc * (0.25 * $cos(0.9) + 0.5 * $sin(0.9)), 0.0, "R8 rot+");
        acc(0, 0, 0.6, 0.0, -1.2,
            kc * 0.6 * $cos(-1.2), kc * 0.6 * $sin(-1.2), 0.0, "R8 rot-");
        acc(0, 1, 0.6, 0.4, 0.0, kc * $sqrt(0.52), 0.0, $atan(0.4 / 0.6), "R9 vec");
        acc(0, 1, 0.5, -0.7, 0.0, kc * $sqrt(0.74), 0.0, $atan(-1.4), "R9 vec-");
        acc(1, 0, 0.75, 0.1, 0.5, 0.75, 0.475, 0.0, "R10 rot");
        acc(1, 1, 1.0, 0.6, 0.0, 1.0, 0.0, 0.6, "R10 vec");
        acc(2, 0, 1.0, 0.0, 0.5, kh * $cosh(0.5), kh * $sinh(0.5), 0.0, "R11 rot");
        acc(2, 1, 1.0, 0.5, 0.0, kh * $sqrt(0.75), 0.0, $atanh(0.5), "R11 vec");
        idle(NST + 2);

        // R6 boundaries: zero angle, zero y, zero vector, extreme values
        send(0, 0, 40000, 0, 0);
        send(2, 0, 30000, 1000, 0);
        send(0, 1, 50000, 0, 0);
        send(1, 1, 0, 0, 0);
        send(0, 1, -131072, 131071, 0);
        send(2, 1, 131071, -131072, 5);
        send(1, 0, -131072, -131072, 65535);
        // R7: bypass code leaves operands untouched
        send(3, 0, 12345, -54321, 777);
        send(3, 1, -131072, 131071, -1);
        idle(2);

        // R2: back-to-back mixed traffic with random gaps
        for (int n = 0; n < 400; n++) begin
            int s;
            s = $urandom_range(0, 9);
            s = (s < 3) ? 0 : (s < 6) ? 2 : (s < 8) ? 1 : 3;
            send(s, $urandom_range(0, 1),
                 int'($urandom_range(0, 262143)) - 131072,
                 int'($urandom_range(0, 262143)) - 131072,
                 int'($urandom_range(0, 262143)) - 131072);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(NST + 4);

        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R2 pending actual=%0d expected=0", expq.size());
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule